// File: doc/BRIEF.md
# Programmable Down-Counting Timer Core

This block is one timer channel behind a small register window of eight 32-bit words. Software sets a reload value, picks a counting mode and a counter width, and turns the channel on. After that the counter steps down once for each prescaled tick. The prescaler passes the `tick_en` strobe straight through, or divides it by 16 or by 256. When the counter is at zero and a step arrives, an expiry event occurs. The event latches a raw interrupt flag. If the interrupt enable bit is set, that flag drives a level interrupt line.

There are three counting modes. Periodic mode reloads the stored limit after each expiry. Free-running mode reloads the all-ones value for the selected width and never uses the limit. One-shot mode stops at zero after its first expiry. There are two ways to write the limit. A direct load also restarts the count at once. A background load only changes the value that the next natural reload will use. Read data and the interrupt line are both registered.

Top module: `dtimer_core`

## Requirements
- R1: The register index is `reg_addr[4:2]`: 0 direct load, 1 current value, 2 control, 3 interrupt clear, 4 raw status, 5 masked status, 6 background load. A read of index 7 returns 0. `reg_rdata` shows the word addressed in the previous cycle.
- R2: The control word is bit 0 one-shot, bit 1 32-bit width, bits 3:2 prescale select, bit 5 interrupt enable, bit 6 periodic and bit 7 run. The control word reads back as `{24'b0, ctrl[7:0]}`.
- R3: After reset the control word reads 0x20, the limit and the count read 0, and `irq_o` is low.
- R4: A prescale select of 0 steps on every `tick_en`, 1 steps on every 16th and 2 steps on every 256th. Counting restarts from the first tick after each control write.
- R5: A write to index 0 stores the limit and immediately sets the count to the reload value. That value is the limit in periodic or one-shot mode, and all-ones for the width in free-running mode.
- R6: A write to index 6 stores the limit but leaves the count as it is until the next reload. Indices 0 and 6 both read the stored limit.
- R7: Writes to index 1 do not change the count.
- R8: Any write to index 3 clears the raw flag. If an expiry happens in the same cycle, the expiry wins.
- R9: Masked status reads raw flag AND interrupt enable. `irq_o` follows that product one cycle later.
- R10: In periodic mode, a step at count zero sets the raw flag and reloads the limit. Other steps decrement the count.
- R11: In one-shot mode the first expiry leaves the count at zero. Later steps do not count and do not set the flag, until a direct load.
- R12: With both periodic and one-shot clear the timer is free-running and expiry reloads 0xFFFFFFFF in 32-bit width or 0x0000FFFF in 16-bit width. In 16-bit width, bits 31:16 of the value read 0.
- R13: With the run bit clear, ticks change neither the count nor the prescaler.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_en | input | 1 | Count tick strobe, one cycle per tick |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 5 | Byte address within the window |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Registered read data |
| irq_o | output | 1 | Level interrupt |

## Verification
A wrong count shows up on the value read-back on the next read. A wrong reload or mode decision shows up when the flag rises one step late or one step early. An error in the raw flag or in the enable gating reaches `irq_o` exactly one cycle after the faulty state. Divider mistakes appear within at most 256 ticks, because the first step lands on the wrong tick. The bench therefore reads the count and the status just before and just after each expected expiry, and on both sides of every divider boundary.

// File: rtl/dtimer_pkg.sv
package dtimer_pkg;
  localparam int IDX_LOAD  = 0;
  localparam int IDX_VALUE = 1;
  localparam int IDX_CTRL  = 2;
  localparam int IDX_CLR   = 3;
  localparam int IDX_RAW   = 4;
  localparam int IDX_MASK  = 5;
  localparam int IDX_BGLD  = 6;

  // Control word, bit 7 down to bit 0.
  typedef struct packed {
    logic       run;
    logic       rep;
    logic       ien;
    logic       rsv;
    logic [1:0] pdiv;
    logic       wide;
    logic       single;
  } ctl_t;

  localparam logic [7:0] CTL_RESET = 8'h20;
endpackage

// File: rtl/dtimer_prescale.sv
module dtimer_prescale #(
  parameter int PW = 8
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       clr,
  input  logic       tick,
  input  logic       run,
  input  logic [1:0] sel,
  output logic       step
);
  localparam int LO = (PW < 4) ? PW : 4;
  localparam int HI = (PW < 8) ? PW : 8;

  logic [PW-1:0] pc;
  logic          hit;

  always_ff @(posedge clk) begin
    if (rst || clr) pc <= '0;
    else if (run && tick) pc <= pc + 1'b1;
  end

  always_comb begin
    case (sel)
      2'd1:    hit = &pc[LO-1:0];
      2'd2:    hit = &pc[HI-1:0];
      default: hit = 1'b1;
    endcase
  end

  assign step = run && tick && hit;
endmodule

// File: rtl/dtimer_count.sv
module dtimer_count #(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          step,
  input  logic          load_now,
  input  logic [DW-1:0] load_val,
  input  logic [DW-1:0] limit,
  input  logic          single,
  input  logic          rep,
  input  logic          wide,
  output logic [DW-1:0] count,
  output logic          fire,
  output logic          done
);
  localparam int HW = DW / 2;

  logic          free_run;
  logic          at_zero;
  logic [DW-1:0] ones;
  logic [DW-1:0] lo_mask;

  assign free_run = !single && !rep;
  assign lo_mask  = {{HW{1'b0}}, {HW{1'b1}}};
  assign ones     = wide ? {DW{1'b1}} : lo_mask;
  assign at_zero  = wide ? (count == '0) : (count[HW-1:0] == '0);
  assign fire     = step && !done && at_zero && !load_now;

  always_ff @(posedge clk) begin
    if (rst) begin
      count <= '0;
      done  <= 1'b0;
    end else if (load_now) begin
      count <= free_run ? ones : load_val;
      done  <= 1'b0;
    end else begin
      if (!single) done <= 1'b0;
      if (step && !done) begin
        if (at_zero) begin
          if (single)        done  <= 1'b1;
          else if (free_run) count <= ones;
          else               count <= wide ? limit : (limit & lo_mask);
        end else if (wide) begin
          count <= count - 1'b1;
        end else begin
          count <= {{HW{1'b0}}, count[HW-1:0] - 1'b1};
        end
      end
    end
  end
endmodule

// File: rtl/dtimer_core.sv
module dtimer_core
  import dtimer_pkg::*;
#(
  parameter int DW = 32,
  parameter int AW = 5,
  parameter int PW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tick_en,
  input  logic          reg_we,
  input  logic [AW-1:0] reg_addr,
  input  logic [DW-1:0] reg_wdata,
  output logic [DW-1:0] reg_rdata,
  output logic          irq_o
);
  localparam int HW = DW / 2;

  ctl_t          ctrl_q;
  logic [DW-1:0] limit_q;
  logic          raw_q;
  logic [2:0]    idx;
  logic          we_load, we_ctrl, we_clr, we_bgld;
  logic          step, fire, done;
  logic [DW-1:0] cnt;
  logic [DW-1:0] cnt_view;
  logic [DW-1:0] rd_mux;

  assign idx     = reg_addr[4:2];
  assign we_load = reg_we && (idx == 3'(IDX_LOAD));
  assign we_ctrl = reg_we && (idx == 3'(IDX_CTRL));
  assign we_clr  = reg_we && (idx == 3'(IDX_CLR));
  assign we_bgld = reg_we && (idx == 3'(IDX_BGLD));

  dtimer_prescale #(.PW(PW)) u_pre (
    .clk  (clk),
    .rst  (rst),
    .clr  (we_ctrl),
    .tick (tick_en),
    .run  (ctrl_q.run),
    .sel  (ctrl_q.pdiv),
    .step (step)
  );

  dtimer_count #(.DW(DW)) u_cnt (
    .clk      (clk),
    .rst      (rst),
    .step     (step),
    .load_now (we_load),
    .load_val (reg_wdata),
    .limit    (limit_q),
    .single   (ctrl_q.single),
    .rep      (ctrl_q.rep),
    .wide     (ctrl_q.wide),
    .count    (cnt),
    .fire     (fire),
    .done     (done)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q  <= ctl_t'(CTL_RESET);
      limit_q <= '0;
      raw_q   <= 1'b0;
      irq_o   <= 1'b0;
    end else begin
      if (we_ctrl) ctrl_q <= ctl_t'(reg_wdata[7:0]);
      if (we_load || we_bgld) limit_q <= reg_wdata;
      if (fire)        raw_q <= 1'b1;
      else if (we_clr) raw_q <= 1'b0;
      irq_o <= raw_q && ctrl_q.ien;
    end
  end

  assign cnt_view = ctrl_q.wide ? cnt : {{HW{1'b0}}, cnt[HW-1:0]};

  always_comb begin
    case (idx)
      3'(IDX_LOAD), 3'(IDX_BGLD): rd_mux = limit_q;
      3'(IDX_VALUE):              rd_mux = cnt_view;
      3'(IDX_CTRL):               rd_mux = {{(DW-8){1'b0}}, ctrl_q};
      3'(IDX_RAW):                rd_mux = {{(DW-1){1'b0}}, raw_q};
      3'(IDX_MASK):               rd_mux = {{(DW-1){1'b0}}, raw_q && ctrl_q.ien};
      default:                    rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) reg_rdata <= '0;
    else     reg_rdata <= rd_mux;
  end
endmodule

// File: rtl/dtimer_checker.sv
module dtimer_checker #(
  parameter int DW = 32,
  parameter int AW = 5
) (
  input logic          clk,
  input logic          rst,
  input logic          reg_we,
  input logic [AW-1:0] reg_addr,
  input logic [DW-1:0] reg_rdata,
  input logic          irq_o,
  input logic [7:0]    ctrl_q,
  input logic [DW-1:0] cnt,
  input logic          step,
  input logic          fire,
  input logic          done,
  input logic          raw_q
);
  logic [2:0] ix;
  assign ix = reg_addr[4:2];

  a_r3_reset_state: assert property (@(posedge clk)
    rst |=> (ctrl_q == 8'h20 && !irq_o && cnt == '0));

  a_r7_value_write_ignored: assert property (@(posedge clk) disable iff (rst)
    (reg_we && ix == 3'd1 && !step) |=> $stable(cnt));

  a_r6_bgload_keeps_count: assert property (@(posedge clk) disable iff (rst)
    (reg_we && ix == 3'd6 && !step) |=> $stable(cnt));

  a_r8_clear_drops_raw: assert property (@(posedge clk) disable iff (rst)
    (reg_we && ix == 3'd3 && !fire) |=> !raw_q);

  a_r9_irq_needs_enable: assert property (@(posedge clk) disable iff (rst)
    !ctrl_q[5] |=> !irq_o);

  a_r11_oneshot_stays: assert property (@(posedge clk) disable iff (rst)
    (done && ctrl_q[0] && !(reg_we && ix == 3'd0)) |=> $stable(cnt));

  a_r12_narrow_upper_zero: assert property (@(posedge clk) disable iff (rst)
    (ix == 3'd1 && !ctrl_q[1]) |=> (reg_rdata[DW-1:DW/2] == '0));

  a_r13_idle_holds: assert property (@(posedge clk) disable iff (rst)
    (!ctrl_q[7] && !(reg_we && ix == 3'd0)) |=> $stable(cnt));
endmodule

bind dtimer_core dtimer_checker #(.DW(DW), .AW(AW)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .reg_we    (reg_we),
  .reg_addr  (reg_addr),
  .reg_rdata (reg_rdata),
  .irq_o     (irq_o),
  .ctrl_q    (ctrl_q),
  .cnt       (cnt),
  .step      (step),
  .fire      (fire),
  .done      (done),
  .raw_q     (raw_q)
);

// File: tb/tb_dtimer_core.sv
module tb_dtimer_core;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        tick_en = 1'b0;
  logic        reg_we = 1'b0;
  logic [4:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        irq_o;

  int n_chk  = 0;
  int n_fail = 0;
  bit ended  = 0;

  always #5 clk = ~clk;

  dtimer_core dut (
    .clk(clk), .rst(rst), .tick_en(tick_en), .reg_we(reg_we),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .irq_o(irq_o)
  );

  typedef struct packed {
    logic        wr;
    logic [2:0]  idx;
    logic [31:0] data;
    logic [31:0] exp;
    logic [7:0]  req;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VEC [NV] = '{
    '{1'b0, 3'd2, 32'h0,        32'h20,       8'd3},  // R3 control reset
    '{1'b0, 3'd1, 32'h0,        32'h0,        8'd3},  // R3 count reset
    '{1'b0, 3'd4, 32'h0,        32'h0,        8'd3},  // R3 raw reset
    '{1'b0, 3'd7, 32'h0,        32'h0,        8'd1},  // R1 undefined index
    '{1'b1, 3'd0, 32'h12345678, 32'h0,        8'd5},  // R5 load in free mode
    '{1'b0, 3'd0, 32'h0,        32'h12345678, 8'd6},  // R6 limit read at 0
    '{1'b0, 3'd1, 32'h0,        32'h0000FFFF, 8'd5},  // R5 free 16-bit reload
    '{1'b1, 3'd1, 32'h0000ABCD, 32'h0,        8'd7},  // R7 value write
    '{1'b0, 3'd1, 32'h0,        32'h0000FFFF, 8'd7},  // R7 unchanged
    '{1'b1, 3'd6, 32'h0000CAFE, 32'h0,        8'd6},  // R6 background load
    '{1'b0, 3'd6, 32'h0,        32'h0000CAFE, 8'd6},  // R6 limit read at 6
    '{1'b0, 3'd5, 32'h0,        32'h0,        8'd9}   // R9 masked with raw clear
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] i, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = {i, 2'b00}; reg_wdata = d;
    @(posedge clk);
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] i, input string tag, input logic [31:0] exp);
    @(negedge clk);
    reg_we = 1'b0; reg_addr = {i, 2'b00};
    @(posedge clk);
    @(negedge clk);
    chk(tag, reg_rdata, exp);
  endtask

  task automatic ticks(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      tick_en = 1'b1;
      @(posedge clk);
      @(negedge clk);
      tick_en = 1'b0;
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    chk("R3 irq after reset", {31'b0, irq_o}, 32'h0);

    for (int v = 0; v < NV; v++) begin
      if (VEC[v].wr) wr(VEC[v].idx, VEC[v].data);
      else rd(VEC[v].idx, $sformatf("R%0d vector %0d", VEC[v].req, v), VEC[v].exp);
    end

    wr(3'd2, 32'hFFFF_FF5C);
    rd(3'd2, "R2 control readback", 32'h5C);

    // R10 periodic
    wr(3'd2, 32'hE2); wr(3'd0, 32'd3);
    ticks(3);
    rd(3'd1, "R10 count at zero", 32'd0);
    rd(3'd4, "R10 no flag before expiry", 32'd0);
    ticks(1);
    rd(3'd1, "R10 reload limit", 32'd3);
    rd(3'd4, "R10 raw set", 32'd1);
    rd(3'd5, "R9 masked set", 32'd1);
    chk("R9 irq high", {31'b0, irq_o}, 32'd1);
    wr(3'd3, 32'h0);
    rd(3'd4, "R8 raw cleared", 32'd0);
    chk("R8 irq low", {31'b0, irq_o}, 32'd0);

    // R6 background load
    wr(3'd6, 32'd10);
    rd(3'd1, "R6 count kept", 32'd3);
    rd(3'd0, "R6 limit at 0", 32'd10);
    ticks(4);
    rd(3'd1, "R6 next reload uses new limit", 32'd10);
    wr(3'd3, 32'h0);

    // R11 one-shot
    wr(3'd2, 32'hA3); wr(3'd0, 32'd2);
    ticks(2);
    rd(3'd4, "R11 no flag yet", 32'd0);
    ticks(1);
    rd(3'd4, "R11 expiry flag", 32'd1);
    wr(3'd3, 32'h0);
    ticks(5);
    rd(3'd1, "R11 held at zero", 32'd0);
    rd(3'd4, "R11 no second expiry", 32'd0);
    wr(3'd0, 32'd2);
    ticks(3);
    rd(3'd4, "R11 rearmed by load", 32'd1);
    wr(3'd3, 32'h0);

    // R12 free-running widths
    wr(3'd2, 32'hE2); wr(3'd0, 32'd1);
    wr(3'd2, 32'hA0);
    ticks(2);
    rd(3'd1, "R12 16-bit wrap", 32'h0000FFFF);
    rd(3'd4, "R12 16-bit expiry flag", 32'd1);
    wr(3'd3, 32'h0);
    ticks(1);
    rd(3'd1, "R12 16-bit decrement", 32'h0000FFFE);
    wr(3'd2, 32'hE2); wr(3'd0, 32'd0);
    wr(3'd2, 32'hA2);
    ticks(1);
    rd(3'd1, "R12 32-bit wrap", 32'hFFFFFFFF);
    wr(3'd3, 32'h0);
    wr(3'd0, 32'h55);
    rd(3'd1, "R5 free load ignores value", 32'hFFFFFFFF);
    rd(3'd0, "R5 limit stored", 32'h55);

    // R4 prescaler
    wr(3'd2, 32'hE6); wr(3'd0, 32'd5);
    ticks(15);
    rd(3'd1, "R4 div16 before", 32'd5);
    ticks(1);
    rd(3'd1, "R4 div16 step", 32'd4);
    wr(3'd2, 32'hEA);
    ticks(255);
    rd(3'd1, "R4 div256 before", 32'd4);
    ticks(1);
    rd(3'd1, "R4 div256 step", 32'd3);

    // R9 enable gating
    wr(3'd2, 32'hC2); wr(3'd0, 32'd0);
    ticks(1);
    rd(3'd4, "R9 raw without enable", 32'd1);
    rd(3'd5, "R9 masked without enable", 32'd0);
    chk("R9 irq gated", {31'b0, irq_o}, 32'd0);
    wr(3'd2, 32'hE2);
    rd(3'd5, "R9 masked with enable", 32'd1);
    chk("R9 irq after enable", {31'b0, irq_o}, 32'd1);
    wr(3'd3, 32'h0);

    // R13 stopped
    wr(3'd2, 32'h62); wr(3'd0, 32'd7);
    ticks(4);
    rd(3'd1, "R13 stopped count", 32'd7);

    if (!ended) begin
      ended = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!ended) begin
      ended = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end
endmodule